// File: doc/BRIEF.md
# Dual-Pass Viterbi Traceback Unit

This block is the survivor-path back end of a four-state (constraint length 3) Viterbi decoder. Each trellis stage, an upstream add-compare-select stage offers one decision vector holding one bit per state. The block stores these vectors in a circular survivor buffer that spans 2L stages, where L is the traceback length. Once enough stages are stored, it stops accepting input and walks the stored trellis backwards twice.

The first walk starts in state 0 at the newest stage and goes back L stages. It produces no data. Its only purpose is to reach a state that is very likely to lie on the true path. The second walk starts from that state and goes back a further L stages, recovering one decoded bit per stage. These bits appear newest-first, so a bit stack of depth L reverses them and the block emits them oldest-first.

The first block needs 2L stored stages. After that, each new block needs only L fresh stages. The L stages used for convergence in one block become the decoded half of the next block, so the decoded stream is continuous.

The controller has four named states:
- FILL: accept vectors.
- SEEK: first pass.
- TRACE: second pass, pushing bits onto the stack.
- EMIT: pop the stack onto the output.

It has four transitions:
- FILL→SEEK when the fill target is reached.
- SEEK→TRACE after L steps.
- TRACE→EMIT after L steps.
- EMIT→FILL after L output bits.

Top module: `dual_traceback`

## Requirements
- R1: A synchronous active-high reset puts the controller in FILL with `dec_ready` = 1 and `out_valid` = 0, clears the stage counter, and makes the next fill target 2L vectors. This holds even when reset arrives in the middle of a block.
- R2: A vector is stored only in a cycle where `dec_valid` and `dec_ready` are both 1. A vector offered while `dec_ready` is 0 has no effect on any later decoded bit.
- R3: After reset, traceback starts only once 2L vectors have been accepted. Each later block starts after L more accepted vectors. In the cycle after the vector that completes a fill, `dec_ready` is 0.
- R4: The first pass begins in state 0 at the most recently stored stage, walks back L stages, and emits no data.
- R5: One traceback step works as follows:
  - The decision vector holds the bit for state s at bit position s.
  - From state s with stored bit d, the predecessor state is {d, s[1]}.
  - The decoded bit for a stage is bit 0 of the state reached at that stage.
- R6: The second pass starts from the state where the first pass ended. It covers the L stages just older than those the first pass visited.
- R7: The decoded bits of a block are output oldest stage first, with `out_valid` high for exactly L consecutive cycles. The first of those cycles comes 2L+1 cycles after the clock edge that accepted the completing vector.
- R8: `dec_ready` stays 0 for exactly 3L consecutive cycles per block (SEEK, TRACE and EMIT). `dec_ready` and `out_valid` are never high together.
- R9: With decisions that describe an error-free path, the output stream equals the encoder input bit stream, in order.
- R10: Block k after reset outputs the decoded bits of stages kL through kL+L−1. The stages that were accepted but not yet decoded are exactly the last accepted stages not covered by a completed block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | A decision vector is offered |
| dec_vec | input | 4 | Decision bits, bit s for state s |
| dec_ready | output | 1 | Block can accept a vector (FILL state) |
| out_valid | output | 1 | A decoded bit is presented |
| out_bit | output | 1 | Decoded bit, oldest stage first |

## Verification
The assertions guard the following on every cycle:
- The handshake exclusivity between input acceptance and output.
- The write pointer holding steady when nothing is accepted.
- The first pass being seeded with state 0 at the newest stored stage.
- The bit stack never overflowing or underflowing.
- Every output burst lasting exactly L cycles.

Only the bench scenarios can show that the decoded values are correct. For that, the bench compares the output against an arithmetic traceback model fed with random decision vectors, and against the raw encoder input on error-free paths. The bench scenarios also show that vectors offered during busy periods leave the result untouched, that reset in the middle of a block restarts cleanly, and that the block-to-block stream has no gaps.

// File: rtl/dtb_pkg.sv
package dtb_pkg;

    localparam int NUM_STATES = 4;
    localparam int STATE_W    = 2;

    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_SEEK  = 2'd1,
        ST_TRACE = 2'd2,
        ST_EMIT  = 2'd3
    } dtb_state_e;

    typedef logic [NUM_STATES-1:0] dec_vec_t;
    typedef logic [STATE_W-1:0]    trel_state_t;

    // One traceback step: predecessor of state s is {decision bit of s, s[1]}
    function automatic trel_state_t tb_step(input dec_vec_t vec, input trel_state_t s);
        return {vec[s], s[1]};
    endfunction

endpackage

// File: rtl/dtb_survivor_buf.sv
module dtb_survivor_buf
    import dtb_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic                         clk,
    input  logic                         wr_en,
    input  logic [$clog2(DEPTH)-1:0]     wr_addr,
    input  dec_vec_t                     wr_data,
    input  logic [$clog2(DEPTH)-1:0]     rd_addr,
    output dec_vec_t                     rd_vec
);

    dec_vec_t store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

    assign rd_vec = store[rd_addr];

endmodule

// File: rtl/dtb_bit_stack.sv
module dtb_bit_stack #(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  logic push_bit,
    input  logic pop,
    output logic top_bit
);

    localparam int SW = $clog2(DEPTH + 1);
    localparam int IW = $clog2(DEPTH);

    logic [DEPTH-1:0] bits_q;
    logic [SW-1:0]    sp_q;
    logic             empty;
    logic             full;
    logic [IW-1:0]    wr_idx;
    logic [IW-1:0]    top_idx;

    assign empty   = (sp_q == '0);
    assign full    = (sp_q == SW'(DEPTH));
    assign wr_idx  = IW'(sp_q);
    assign top_idx = IW'(sp_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= '0;
        end else if (push) begin
            sp_q <= sp_q + 1'b1;
        end else if (pop) begin
            sp_q <= sp_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            bits_q[wr_idx] <= push_bit;
        end
    end

    assign top_bit = empty ? 1'b0 : bits_q[top_idx];

    // R7
    stack_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    // R7
    stack_udf_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

    // R7
    stack_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(push && pop));

endmodule

// File: rtl/dtb_ctrl.sv
module dtb_ctrl
    import dtb_pkg::*;
#(
    parameter int L = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        dec_valid,
    output logic                        dec_ready,
    output logic                        wr_en,
    output logic [$clog2(2*L)-1:0]      wr_addr,
    output logic [$clog2(2*L)-1:0]      rd_addr,
    input  dec_vec_t                    rd_vec,
    output logic                        push,
    output logic                        push_bit,
    output logic                        pop,
    output logic                        out_valid
);

    localparam int DEPTH = 2 * L;
    localparam int AW    = $clog2(DEPTH);
    localparam logic [AW-1:0] LAST_L    = AW'(L - 1);
    localparam logic [AW-1:0] LAST_FULL = AW'(DEPTH - 1);
    localparam logic [AW-1:0] TOP_ADDR  = AW'(DEPTH - 1);

    dtb_state_e  state_q, state_d;
    logic [AW-1:0] cnt_q;
    logic [AW-1:0] wr_ptr_q;
    logic [AW-1:0] rd_ptr_q;
    trel_state_t   trace_q;
    trel_state_t   trace_prev;
    logic          primed_q;
    logic          accept;
    logic          fill_last;
    logic          step_last;
    logic [AW-1:0] fill_target;

    assign accept      = dec_valid && dec_ready;
    assign fill_target = primed_q ? LAST_L : LAST_FULL;
    assign fill_last   = accept && (cnt_q == fill_target);
    assign step_last   = (cnt_q == LAST_L);
    assign trace_prev  = tb_step(rd_vec, trace_q);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL:  if (fill_last) state_d = ST_SEEK;
            ST_SEEK:  if (step_last) state_d = ST_TRACE;
            ST_TRACE: if (step_last) state_d = ST_EMIT;
            ST_EMIT:  if (step_last) state_d = ST_FILL;
        endcase
    end

    // Counters, pointers and trace state
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            trace_q  <= '0;
            primed_q <= 1'b0;
        end else begin
            if (state_d != state_q) begin
                cnt_q <= '0;
            end else if (state_q != ST_FILL || accept) begin
                cnt_q <= cnt_q + 1'b1;
            end

            if (accept) begin
                wr_ptr_q <= (wr_ptr_q == TOP_ADDR) ? '0 : wr_ptr_q + 1'b1;
            end

            unique case (state_q)
                ST_FILL: begin
                    if (fill_last) begin
                        rd_ptr_q <= wr_ptr_q;
                        trace_q  <= '0;
                    end
                end
                ST_SEEK, ST_TRACE: begin
                    rd_ptr_q <= (rd_ptr_q == '0) ? TOP_ADDR : rd_ptr_q - 1'b1;
                    trace_q  <= trace_prev;
                end
                ST_EMIT: begin
                    if (step_last) begin
                        primed_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        dec_ready = 1'b0;
        push      = 1'b0;
        pop       = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_FILL:  dec_ready = 1'b1;
            ST_SEEK:  ;
            ST_TRACE: push      = 1'b1;
            ST_EMIT: begin
                pop       = 1'b1;
                out_valid = 1'b1;
            end
        endcase
    end

    assign wr_en    = accept;
    assign wr_addr  = wr_ptr_q;
    assign rd_addr  = rd_ptr_q;
    assign push_bit = trace_q[0];

    // Checker-only burst length counter
    logic [AW:0] emit_run_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            emit_run_q <= '0;
        end else if (out_valid) begin
            emit_run_q <= emit_run_q + 1'b1;
        end else begin
            emit_run_q <= '0;
        end
    end

    // R8
    hs_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(dec_ready && out_valid));

    // R2
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(dec_valid && dec_ready) |=> $stable(wr_ptr_q));

    // R4
    seek_seed_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FILL && state_d == ST_SEEK) |=>
            (trace_q == '0 && rd_ptr_q == $past(wr_ptr_q)));

    // R7
    burst_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(out_valid) |-> (emit_run_q == (AW+1)'(L)));

endmodule

// File: rtl/dual_traceback.sv
module dual_traceback
    import dtb_pkg::*;
#(
    parameter int L = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  dec_valid,
    input  logic [NUM_STATES-1:0] dec_vec,
    output logic                  dec_ready,
    output logic                  out_valid,
    output logic                  out_bit
);

    localparam int DEPTH = 2 * L;
    localparam int AW    = $clog2(DEPTH);

    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;
    dec_vec_t      rd_vec;
    logic          push;
    logic          push_bit;
    logic          pop;

    dtb_ctrl #(.L(L)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .dec_valid (dec_valid),
        .dec_ready (dec_ready),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .rd_addr   (rd_addr),
        .rd_vec    (rd_vec),
        .push      (push),
        .push_bit  (push_bit),
        .pop       (pop),
        .out_valid (out_valid)
    );

    dtb_survivor_buf #(.DEPTH(DEPTH)) u_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (dec_vec),
        .rd_addr (rd_addr),
        .rd_vec  (rd_vec)
    );

    dtb_bit_stack #(.DEPTH(L)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_bit (push_bit),
        .pop      (pop),
        .top_bit  (out_bit)
    );

endmodule

// File: tb/dual_traceback_tb.sv
`timescale 1ns/1ps
module dual_traceback_tb;

    localparam int L = 4;
    localparam int D = 2 * L;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst;
    logic       dec_valid;
    logic [3:0] dec_vec;
    logic       dec_ready;
    logic       out_valid;
    logic       out_bit;

    dual_traceback #(.L(L)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .dec_valid (dec_valid),
        .dec_vec   (dec_vec),
        .dec_ready (dec_ready),
        .out_valid (out_valid),
        .out_bit   (out_bit)
    );

    int    checks   = 0;
    int    failures = 0;
    int    cyc      = 0;
    bit    finished = 0;
    logic [3:0] hist [0:4095];
    int    n_acc    = 0;
    int    last_done = 0;
    bit    exp_q [$];
    string tag      = "R9";
    logic [1:0] enc = 2'b00;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Arithmetic reference traceback over the stored history (R4 R5 R6)
    task automatic ref_block();
        int s;
        bit bits [L];
        s = 0;
        for (int k = n_acc - 1; k >= n_acc - L; k--)
            s = (hist[k][s] ? 2 : 0) + (s >> 1);
        for (int k = n_acc - 1 - L; k >= n_acc - D; k--) begin
            bits[k - (n_acc - D)] = bit'(s & 1);
            s = (hist[k][s] ? 2 : 0) + (s >> 1);
        end
        for (int i = 0; i < L; i++) exp_q.push_back(bits[i]);
    endtask

    task automatic drive(input int ncyc, input bit use_ref);
        bit just_done;
        just_done = 0;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            if (just_done) chk(dec_ready == 1'b0, "R3 busy after fill", int'(dec_ready), 0);
            just_done = 0;
            dec_valid = (($urandom % 4) != 0);
            if (dec_valid && dec_ready) begin
                logic [3:0] v;
                if (use_ref) begin
                    v = 4'($urandom);
                end else begin
                    bit u;
                    u = bit'($urandom & 1);
                    v = {4{enc[1]}};
                    enc = {enc[0], u};
                    exp_q.push_back(u);
                end
                hist[n_acc] = v;
                n_acc++;
                dec_vec = v;
                if (n_acc >= D && ((n_acc - D) % L) == 0) begin
                    last_done = cyc;
                    just_done = 1;
                    if (use_ref) ref_block();
                end
            end else begin
                // R2: junk offered while busy must be ignored
                dec_vec = 4'($urandom);
            end
        end
        @(negedge clk);
        dec_valid = 1'b0;
    endtask

    task automatic drain_and_check(input bit use_ref);
        int blocks, remaining;
        repeat (4 * D) @(negedge clk);
        blocks    = (n_acc >= D) ? 1 + (n_acc - D) / L : 0;
        remaining = use_ref ? 0 : n_acc - blocks * L;
        chk(exp_q.size() == remaining, "R10 stream continuity", exp_q.size(), remaining);
    endtask

    task automatic do_reset();
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1;
        @(negedge clk);
        chk(dec_ready == 1'b1, "R1 ready after reset", int'(dec_ready), 1);
        chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        exp_q.delete();
        n_acc = 0;
        enc   = 2'b00;
        @(posedge clk); #1 rst = 1'b0;
    endtask

    // Output monitor
    int ov_run = 0;
    int busy_run = 0;
    bit prev_ov = 0;
    always @(negedge clk) begin
        if (rst) begin
            ov_run = 0; busy_run = 0; prev_ov = 0;
        end else begin
            if (out_valid) begin
                if (!prev_ov)
                    chk(cyc - last_done == 2 * L + 1, "R7 latency", cyc - last_done, 2 * L + 1);
                ov_run++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, {tag, " unexpected bit"}, int'(out_bit), -1);
                end else begin
                    bit e;
                    e = exp_q.pop_front();
                    chk(out_bit == e, {tag, " decoded bit"}, int'(out_bit), int'(e));
                end
            end else if (prev_ov) begin
                chk(ov_run == L, "R7 burst length", ov_run, L);
                ov_run = 0;
            end
            chk(!(out_valid && dec_ready), "R8 exclusive", int'(out_valid), 0);
            if (!dec_ready) begin
                busy_run++;
            end else if (busy_run > 0) begin
                chk(busy_run == 3 * L, "R8 busy length", busy_run, 3 * L);
                busy_run = 0;
            end
            prev_ov = out_valid;
        end
    end

    initial begin
        rst = 1'b1; dec_valid = 1'b0; dec_vec = 4'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(dec_ready == 1'b1, "R1 ready in reset", int'(dec_ready), 1);
        chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        @(posedge clk); #1 rst = 1'b0;

        // Error-free path: output equals encoder input (R9, R3)
        tag = "R9";
        drive(600, 1'b0);
        drain_and_check(1'b0);

        // Random decisions against the reference model (R2 R4 R5 R6)
        do_reset();
        tag = "R2 R4 R5 R6";
        drive(1500, 1'b1);
        drain_and_check(1'b1);

        // Reset in the middle of a burst (R1), then resume
        do_reset();
        drive(3 * D, 1'b1);
        while (!out_valid) @(negedge clk);
        do_reset();
        drive(400, 1'b1);
        drain_and_check(1'b1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule